// File: doc/BRIEF.md
# Fraction-of-Rate Digital Modulator

This block shifts interpolated baseband samples up in frequency by multiplying them with a digital local oscillator that runs at a fixed fraction of the sample rate: one half, one quarter or one eighth. A fourth setting passes samples through without any frequency shift. The oscillator is not a phase accumulator. It is a three-bit phase sequencer that steps through a short table of cosine and sine coefficients. Those coefficients take only the values 0, ±1 and ±√½.

In single-channel operation, the I or the Q input is multiplied by a real cosine, which gives a double-sideband result. In dual-channel operation, the I/Q pair is multiplied by a complex exponential. A select input then sends either the real or the imaginary part of the product to the single output stream. A sideband input sets the direction of rotation, and with it which image is cancelled once a partner path is combined downstream. A programmable offset sets the sequencer phase when a synchronization request arrives. This lets several modulators start at aligned or deliberately skewed phases.

The output is registered. Each accepted sample appears one clock later with a valid flag. The output holds its value between samples.

Top module: `frac_rate_mod`

## Requirements
- R1: While rst_ni is low, valid_o and data_o are 0 and the phase sequencer is 0. The first sample after reset, if not synchronized, uses phase 0.
- R2: valid_o is valid_i delayed by one clock. data_o changes only in the clock after an accepted sample and otherwise holds its value.
- R3: mode_i encoding: 00 = no shift, 01 = fs/2, 10 = fs/4, 11 = fs/8. With 00 the coefficient pair is always (cos, sin) = (1, 0). Single mode then outputs the selected channel unchanged. Dual real outputs I and dual imaginary outputs Q.
- R4: The phase sequencer advances by one, modulo 8, on each accepted sample. The LO angle in eighths of a turn is the phase times 4 for fs/2, times 2 for fs/4 and times 1 for fs/8, taken modulo 8. This gives periods of 2, 4 and 8 samples.
- R5: In single mode (dual_i = 0), the output is x·cos, where x is i_i when chan_sel_i = 0 and q_i when chan_sel_i = 1. At fs/2 this gives +x, −x. At fs/4 the cosine sequence is 1, 0, −1, 0.
- R6: In dual mode, with s = +1 when sb_sel_i = 1 (lower image rejected) and s = −1 when sb_sel_i = 0 (upper image rejected): real = I·cos − s·Q·sin and imag = s·I·sin + Q·cos. out_imag_i = 0 selects real and out_imag_i = 1 selects imag.
- R7: Coefficients are signed 16-bit with 14 fractional bits: 1 = 16384 and √½ = 11585. The sum of products is rounded half-up by adding 8192 and shifting right arithmetically by 14, then saturated to [−32768, 32767].
- R8: When sync_i is high, the phase is loaded from phase_ofs_i. If valid_i is high in the same clock, that sample uses the offset phase and the next sample uses the offset plus one.
- R9: The phase offset applies in every shifting mode. The sequencer uses only the low bits the mode needs, so an offset of 5 at fs/4 behaves like 1.
- R10: Clocks without valid_i, and without sync_i, leave the phase sequencer unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sample clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Input sample strobe |
| i_i | input | 16 | In-phase sample, two's complement |
| q_i | input | 16 | Quadrature sample, two's complement |
| mode_i | input | 2 | LO rate select (R3 encoding) |
| dual_i | input | 1 | 1 = complex product, 0 = real product |
| chan_sel_i | input | 1 | Single mode channel: 0 = I, 1 = Q |
| out_imag_i | input | 1 | Dual mode output: 0 = real, 1 = imaginary |
| sb_sel_i | input | 1 | 0 = reject upper image, 1 = reject lower image |
| phase_ofs_i | input | 3 | Phase loaded on synchronization |
| sync_i | input | 1 | Synchronization request |
| valid_o | output | 1 | Output sample strobe |
| data_o | output | 16 | Modulated sample |

## Verification
The assertions check on every cycle that the output strobe follows the input strobe and that data holds between samples. They also check that the sequencer steps, holds or reloads from the offset as sync and valid dictate, that pass-through leaves the I sample intact, and that the fs/4 real product is zero on the odd phases. The exact coefficient values, the sign convention of each sideband, the half-up rounding and the clipping at full scale are only visible in the bench's sweep. That sweep covers every mode, channel, output and sideband combination, with extreme sample values, against an arithmetic model.

// File: rtl/mod_pkg.sv
package mod_pkg;
  localparam int PH_W = 3;

  typedef enum logic [1:0] {
    MOD_NONE    = 2'b00,
    MOD_HALF    = 2'b01,
    MOD_QUARTER = 2'b10,
    MOD_EIGHTH  = 2'b11
  } mod_sel_e;
endpackage

// File: rtl/lo_seq.sv
module lo_seq
  import mod_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 valid_i,
  input  logic                 sync_i,
  input  logic [PH_W-1:0]      ofs_i,
  input  mod_sel_e             mode_i,
  output logic [PH_W-1:0]      phase_o,
  output logic signed [CW-1:0] cos_o,
  output logic signed [CW-1:0] sin_o
);
  localparam int FR = CW - 2;
  localparam int ONE_I = 1 << FR;
  localparam int RT_I = int'(0.7071067811865476 * (2.0 ** FR));
  localparam logic signed [CW-1:0] ONE = CW'(ONE_I);
  localparam logic signed [CW-1:0] RT = CW'(RT_I);

  logic [PH_W-1:0] ph_q, eph;
  logic [PH_W-1:0] ang;

  assign eph = sync_i ? ofs_i : ph_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      ph_q <= '0;
    else if (valid_i) ph_q <= eph + PH_W'(1);
    else if (sync_i)  ph_q <= ofs_i;
  end

  // angle in eighths of a turn
  always_comb begin
    unique case (mode_i)
      MOD_HALF:    ang = {eph[0], 2'b00};
      MOD_QUARTER: ang = {eph[1:0], 1'b0};
      MOD_EIGHTH:  ang = eph;
      default:     ang = '0;
    endcase
  end

  always_comb begin
    unique case (ang)
      3'd0:    begin cos_o = ONE;  sin_o = '0;   end
      3'd1:    begin cos_o = RT;   sin_o = RT;   end
      3'd2:    begin cos_o = '0;   sin_o = ONE;  end
      3'd3:    begin cos_o = -RT;  sin_o = RT;   end
      3'd4:    begin cos_o = -ONE; sin_o = '0;   end
      3'd5:    begin cos_o = -RT;  sin_o = -RT;  end
      3'd6:    begin cos_o = '0;   sin_o = -ONE; end
      default: begin cos_o = RT;   sin_o = -RT;  end
    endcase
  end

  assign phase_o = ph_q;
endmodule

// File: rtl/cmac.sv
module cmac #(
  parameter int DW = 16,
  parameter int CW = 16,
  localparam int AW = DW + CW + 1
) (
  input  logic signed [DW-1:0] a_i,
  input  logic signed [CW-1:0] c_i,
  input  logic signed [DW-1:0] b_i,
  input  logic signed [CW-1:0] d_i,
  output logic signed [AW-1:0] sum_o
);
  logic signed [AW-1:0] p0, p1;
  assign p0 = AW'(a_i) * AW'(c_i);
  assign p1 = AW'(b_i) * AW'(d_i);
  assign sum_o = p0 + p1;
endmodule

// File: rtl/rnd_sat.sv
module rnd_sat #(
  parameter int AW = 33,
  parameter int DW = 16,
  parameter int FR = 14
) (
  input  logic signed [AW-1:0] acc_i,
  output logic signed [DW-1:0] y_o
);
  localparam logic signed [AW:0] HALF = (AW+1)'(1) <<< (FR - 1);
  localparam logic signed [AW:0] MAXV = (AW+1)'((1 << (DW - 1)) - 1);
  localparam logic signed [AW:0] MINV = -((AW+1)'(1) <<< (DW - 1));

  logic signed [AW:0] biased, shifted;
  assign biased  = (AW+1)'(acc_i) + HALF;
  assign shifted = biased >>> FR;

  always_comb begin
    if (shifted > MAXV)      y_o = MAXV[DW-1:0];
    else if (shifted < MINV) y_o = MINV[DW-1:0];
    else                     y_o = shifted[DW-1:0];
  end
endmodule

// File: rtl/frac_rate_mod.sv
module frac_rate_mod
  import mod_pkg::*;
#(
  parameter int DW = 16,
  parameter int CW = 16
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            valid_i,
  input  logic [DW-1:0]   i_i,
  input  logic [DW-1:0]   q_i,
  input  logic [1:0]      mode_i,
  input  logic            dual_i,
  input  logic            chan_sel_i,
  input  logic            out_imag_i,
  input  logic            sb_sel_i,
  input  logic [PH_W-1:0] phase_ofs_i,
  input  logic            sync_i,
  output logic            valid_o,
  output logic [DW-1:0]   data_o
);
  localparam int AW = DW + CW + 1;
  localparam int FR = CW - 2;

  logic [PH_W-1:0]      phase;
  logic signed [CW-1:0] lo_cos, lo_sin, sin_rot;
  logic signed [DW-1:0] op_a, op_b;
  logic signed [CW-1:0] op_c, op_d;
  logic signed [AW-1:0] acc;
  logic signed [DW-1:0] y;
  logic                 vld_q;
  logic [DW-1:0]        dat_q;

  lo_seq #(.CW(CW)) u_lo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .valid_i (valid_i),
    .sync_i  (sync_i),
    .ofs_i   (phase_ofs_i),
    .mode_i  (mod_sel_e'(mode_i)),
    .phase_o (phase),
    .cos_o   (lo_cos),
    .sin_o   (lo_sin)
  );

  // rotation sign: reject lower image -> positive rotation
  assign sin_rot = sb_sel_i ? lo_sin : -lo_sin;

  always_comb begin
    op_c = lo_cos;
    if (!dual_i) begin
      op_a = chan_sel_i ? $signed(q_i) : $signed(i_i);
      op_b = '0;
      op_d = '0;
    end else if (!out_imag_i) begin
      op_a = $signed(i_i);
      op_b = $signed(q_i);
      op_d = -sin_rot;
    end else begin
      op_a = $signed(q_i);
      op_b = $signed(i_i);
      op_d = sin_rot;
    end
  end

  cmac #(.DW(DW), .CW(CW)) u_mac (
    .a_i   (op_a),
    .c_i   (op_c),
    .b_i   (op_b),
    .d_i   (op_d),
    .sum_o (acc)
  );

  rnd_sat #(.AW(AW), .DW(DW), .FR(FR)) u_rs (
    .acc_i (acc),
    .y_o   (y)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q <= 1'b0;
      dat_q <= '0;
    end else begin
      vld_q <= valid_i;
      if (valid_i) dat_q <= y;
    end
  end

  assign valid_o = vld_q;
  assign data_o  = dat_q;
endmodule

// File: rtl/frac_rate_mod_chk.sv
module frac_rate_mod_chk #(
  parameter int DW = 16
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          valid_i,
  input logic [DW-1:0] i_i,
  input logic [1:0]    mode_i,
  input logic          dual_i,
  input logic          chan_sel_i,
  input logic [2:0]    phase_ofs_i,
  input logic          sync_i,
  input logic          valid_o,
  input logic [DW-1:0] data_o,
  input logic [2:0]    phase
);
  p_vld_on_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);
  p_vld_off_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o);
  p_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(data_o));
  p_bypass_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && mode_i == 2'b00 && !dual_i && !chan_sel_i) |=> data_o == $past(i_i));
  p_step_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !sync_i) |=> phase == 3'($past(phase) + 3'd1));
  p_idle_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!valid_i && !sync_i) |=> $stable(phase));
  p_sync_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sync_i && !valid_i) |=> phase == $past(phase_ofs_i));
  p_sync_vld_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sync_i && valid_i) |=> phase == 3'($past(phase_ofs_i) + 3'd1));
  p_null_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !sync_i && mode_i == 2'b10 && !dual_i && phase[0]) |=> data_o == '0);
endmodule

bind frac_rate_mod frac_rate_mod_chk #(.DW(DW)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .valid_i     (valid_i),
  .i_i         (i_i),
  .mode_i      (mode_i),
  .dual_i      (dual_i),
  .chan_sel_i  (chan_sel_i),
  .phase_ofs_i (phase_ofs_i),
  .sync_i      (sync_i),
  .valid_o     (valid_o),
  .data_o      (data_o),
  .phase       (phase)
);

// File: tb/frac_rate_mod_test.sv
module frac_rate_mod_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid_i = 1'b0;
  logic [15:0] i_i = '0, q_i = '0;
  logic [1:0]  mode_i = '0;
  logic        dual_i = 1'b0, chan_sel_i = 1'b0, out_imag_i = 1'b0, sb_sel_i = 1'b0;
  logic [2:0]  phase_ofs_i = '0;
  logic        sync_i = 1'b0;
  logic        valid_o;
  logic [15:0] data_o;

  int n_chk = 0, n_bad = 0;
  int ph_m = 0;
  bit done = 0;

  always #5 clk = ~clk;

  frac_rate_mod uut (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid_i), .i_i(i_i), .q_i(q_i),
    .mode_i(mode_i), .dual_i(dual_i), .chan_sel_i(chan_sel_i),
    .out_imag_i(out_imag_i), .sb_sel_i(sb_sel_i), .phase_ofs_i(phase_ofs_i),
    .sync_i(sync_i), .valid_o(valid_o), .data_o(data_o)
  );

  function automatic int rnd_real(real x);
    return (x >= 0.0) ? $rtoi(x + 0.5) : -$rtoi(-x + 0.5);
  endfunction

  function automatic int pat(int k);
    case (k % 8)
      0: return 32767;
      1: return -32768;
      2: return 12345;
      3: return -1;
      4: return 0;
      5: return 1;
      6: return -20000;
      default: return 8191;
    endcase
  endfunction

  function automatic int model(int iv, int qv, int ph);
    int mul, ang, c, s, sg;
    longint acc, y;
    mul = (mode_i == 2'd0) ? 0 : (mode_i == 2'd1) ? 4 : (mode_i == 2'd2) ? 2 : 1;
    ang = (ph * mul) % 8;
    c = rnd_real($cos(ang * 3.141592653589793 / 4.0) * 16384.0);
    s = rnd_real($sin(ang * 3.141592653589793 / 4.0) * 16384.0);
    sg = sb_sel_i ? 1 : -1;
    if (!dual_i)          acc = longint'(chan_sel_i ? qv : iv) * c;
    else if (!out_imag_i) acc = longint'(iv) * c - longint'(sg) * qv * s;
    else                  acc = longint'(sg) * iv * s + longint'(qv) * c;
    y = (acc + 8192) >>> 14;
    if (y > 32767) y = 32767;
    if (y < -32768) y = -32768;
    return int'(y);
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d (mode %0d dual %0d ch %0d im %0d sb %0d)",
               req, act, exp, mode_i, dual_i, chan_sel_i, out_imag_i, sb_sel_i);
    end
  endtask

  // called at a negedge; returns at the negedge after the result
  task automatic send(int iv, int qv, bit sy, int ofs, string req);
    int eph, exp;
    eph = sy ? ofs : ph_m;
    i_i = 16'(iv); q_i = 16'(qv);
    sync_i = sy; phase_ofs_i = 3'(ofs); valid_i = 1'b1;
    exp = model(iv, qv, eph);
    ph_m = (eph + 1) % 8;
    @(posedge clk); @(negedge clk);
    valid_i = 1'b0; sync_i = 1'b0;
    check(valid_o == 1'b1, "R2", int'(valid_o), 1);
    check($signed(data_o) == exp, req, int'($signed(data_o)), exp);
  endtask

  task automatic idle(bit sy, int ofs);
    logic [15:0] prev;
    prev = data_o;
    i_i = 16'h5a5a; q_i = 16'ha5a5; sync_i = sy; phase_ofs_i = 3'(ofs);
    if (sy) ph_m = ofs;
    @(posedge clk); @(negedge clk);
    sync_i = 1'b0;
    check(valid_o == 1'b0, "R2", int'(valid_o), 0);
    check(data_o == prev, "R2", int'($signed(data_o)), int'($signed(prev)));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(valid_o == 1'b0, "R1", int'(valid_o), 0);
    check(data_o == '0, "R1", int'(data_o), 0);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: phase 0 after reset, fs/8 angle 0 passes x
    mode_i = 2'd3;
    send(12345, 0, 1'b0, 0, "R1");
    // R10: idles keep the phase; next sample is phase 1
    idle(1'b0, 0); idle(1'b0, 0);
    send(16384, 0, 1'b0, 0, "R10");
    // R7: saturation at fs/8 angle 45 deg, dual real, lower image rejected
    dual_i = 1'b1; sb_sel_i = 1'b1;
    send(32767, -32768, 1'b1, 1, "R7");
    // R8: sync without valid, then sample uses the offset
    idle(1'b1, 6);
    send(1000, 2000, 1'b0, 0, "R8");
    // R9: offset 5 at fs/4 acts like 1
    mode_i = 2'd2; dual_i = 1'b0;
    send(777, 0, 1'b1, 5, "R9");
    // full sweep over every configuration
    for (int cfg = 0; cfg < 32; cfg++) begin
      string rq;
      mode_i = 2'(cfg >> 3); dual_i = cfg[2]; chan_sel_i = cfg[1];
      out_imag_i = cfg[1]; sb_sel_i = cfg[0];
      rq = (mode_i == 2'd0) ? "R3" : (!dual_i) ? "R5" : (mode_i == 2'd3) ? "R7" : "R6";
      send(pat(cfg), pat(cfg + 3), 1'b1, cfg % 8, "R8");
      for (int k = 0; k < 10; k++) begin
        if (k == 4) idle(1'b0, 0);
        send(pat(cfg + k), pat(cfg * 3 + k + 1), 1'b0, 0, (k == 7) ? "R4" : rq);
      end
    end
    done = 1;
  end

  initial begin
    for (int t = 0; t < 20000; t++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual 0 expected 1 (run finished)");
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule